// File: doc/BRIEF.md
# Workload-Driven Latency Tolerance Reporter

This block lives in a PCIe-style endpoint and tells the platform how long the device can wait for its memory accesses to be served. It watches the device's workload (link state, association, radio-off or low-power-idle, traffic, and buffer fill) and chooses one of several latency tiers. Each tier maps to a tolerance word: a 10-bit value with a 3-bit scale. When the chosen word changes, the block raises a report request toward a message sender through a valid/ready handshake.

The tier machine has five states. `TIER_NOREQ` reports "no requirement". `TIER_ACTIVE` reports the tight traffic value. `TIER_ACT_IDLE` reports the relaxed value. `TIER_IDLE` and `TIER_PLATMAX` both report the firmware platform maximum.

The transitions are checked in this priority order:
- Link down or not associated: any state goes to NOREQ.
- Associated and quiet: any state goes to PLATMAX.
- Busy (traffic, or fill at or above threshold): any state goes to ACTIVE.
- NOREQ or PLATMAX with the conditions cleared: go to ACTIVE.
- ACTIVE after the first timeout: go to ACT_IDLE.
- ACT_IDLE after the second timeout: go to IDLE.

Top module: `lat_tol_reporter`

## Requirements
- R1: After reset the tier is no-requirement, `rpt_valid_o` is 0, `rpt_noreq_o` is 1 and `rpt_word_o` is 0; no report is raised by reset alone.
- R2: While `link_up_i` or `assoc_i` is low, the selection is no-requirement, reported as `rpt_noreq_o`=1 with `rpt_word_o`=0.
- R3: When linked, associated and `quiet_i` is high, the selection is `plat_max_i`, raised to the active word if it decodes to less.
- R4: A tolerance word holds the scale in bits [12:10] and the value in bits [9:0]; it means value × 32^scale ns. Traffic selects the active word: 60 µs, rounded up to scale 2 and value 59 (0x83B).
- R5: After `act_idle_cyc_i` consecutive non-busy cycles in ACTIVE, the tier becomes ACT_IDLE. This tier reports 400 µs, rounded up to scale 2 and value 391 (0x987).
- R6: After `idle_cyc_i` further non-busy cycles in ACT_IDLE, the tier becomes IDLE, which reports the clamped platform maximum.
- R7: A fill level at or above `fill_thr_i` counts as busy. It returns any idle tier to ACTIVE on the next clock and restarts the inactivity count.
- R8: A report is raised only when the selected word or no-requirement flag differs from the last one requested. The report appears two clocks after the input that caused the change.
- R9: `rpt_valid_o` stays high until `rpt_ready_i` is seen. A newer selection that arrives while a report is pending replaces the pending word.
- R10: No reported word decodes to below 60 µs. The relaxed tier is never set below 300 µs.
- R11: A timeout programmed as 0 behaves as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Link is up |
| assoc_i | input | 1 | Device is associated / connected |
| quiet_i | input | 1 | Radio off or low-power idle |
| traffic_i | input | 1 | Traffic is flowing |
| fill_lvl_i | input | FILL_W | Buffer fill level |
| fill_thr_i | input | FILL_W | Fill threshold that forces the active tier |
| plat_max_i | input | 13 | Firmware platform maximum tolerance word |
| act_idle_cyc_i | input | CNT_W | Non-busy cycles before leaving ACTIVE |
| idle_cyc_i | input | CNT_W | Non-busy cycles before leaving ACT_IDLE |
| rpt_ready_i | input | 1 | Message sender accepts the report |
| rpt_valid_o | output | 1 | Report request pending |
| rpt_word_o | output | 13 | Reported tolerance word |
| rpt_noreq_o | output | 1 | Report means "no requirement" |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- The exact clock of each inactivity timeout. An off-by-one counter would report the relaxed word a cycle early or late.
- A timeout programmed as zero. A design that treats zero literally would never leave ACTIVE.
- A platform maximum programmed below 60 µs. Without the clamp, an illegal tight word would leak out.
- A tier change while a report is stalled. A design without replacement would either send the stale word or drop the valid.
- A long stay in a tier with the sender ready. A design that compares against the wrong register would repeat reports.

Randomized inputs and back-pressure are compared every cycle against a bench model built from the requirements.

// File: rtl/lat_tol_pkg.sv
package lat_tol_pkg;

    typedef enum logic [2:0] {
        TIER_NOREQ    = 3'd0,
        TIER_ACTIVE   = 3'd1,
        TIER_ACT_IDLE = 3'd2,
        TIER_IDLE     = 3'd3,
        TIER_PLATMAX  = 3'd4
    } tier_e;

    typedef struct packed {
        logic [2:0] scale;
        logic [9:0] val;
    } lat_word_t;

    localparam longint FLOOR_NS        = 60000;
    localparam longint ACT_IDLE_MIN_NS = 300000;

    // Smallest scale whose rounded-up value fits in ten bits.
    function automatic lat_word_t enc_ns(input longint ns);
        lat_word_t w;
        longint    unit;
        longint    v;
        w.scale = 3'd5;
        w.val   = 10'd1023;
        for (int s = 5; s >= 0; s--) begin
            unit = longint'(1) << (5 * s);
            v    = (ns + unit - 1) / unit;
            if (v <= 1023) begin
                w.scale = 3'(s);
                w.val   = 10'(v);
            end
        end
        return w;
    endfunction

    function automatic logic [47:0] dec_ns(input lat_word_t w);
        logic [5:0] sh;
        sh = 6'(w.scale) * 6'd5;
        return 48'(w.val) << sh;
    endfunction

endpackage

// File: rtl/lat_tol_tier_fsm.sv
module lat_tol_tier_fsm
    import lat_tol_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up_i,
    input  logic             assoc_i,
    input  logic             quiet_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] t1_i,
    input  logic [CNT_W-1:0] t2_i,
    output tier_e            tier_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tier_e            state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] t1_eff, t2_eff;
    logic [CNT_W:0]   cnt_inc;
    logic             hit1, hit2, present;

    assign t1_eff  = (t1_i == '0) ? ONE : t1_i;  // R11
    assign t2_eff  = (t2_i == '0) ? ONE : t2_i;  // R11
    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign hit1    = cnt_inc >= {1'b0, t1_eff};
    assign hit2    = cnt_inc >= {1'b0, t2_eff};
    assign present = link_up_i && assoc_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!present) begin
            state_d = TIER_NOREQ;
            cnt_d   = '0;
        end else if (quiet_i) begin
            state_d = TIER_PLATMAX;
            cnt_d   = '0;
        end else if (busy_i) begin
            state_d = TIER_ACTIVE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TIER_NOREQ, TIER_PLATMAX: begin
                    state_d = TIER_ACTIVE;
                    cnt_d   = '0;
                end
                TIER_ACTIVE: begin
                    if (hit1) begin
                        state_d = TIER_ACT_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
                TIER_ACT_IDLE: begin
                    if (hit2) begin
                        state_d = TIER_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
                TIER_IDLE: begin
                    state_d = TIER_IDLE;
                end
                default: begin
                    state_d = TIER_NOREQ;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TIER_NOREQ;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        tier_o = state_q;
    end

    a_r2_drop_to_noreq: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> tier_o == TIER_NOREQ);

    a_r3_quiet_platmax: assert property (@(posedge clk) disable iff (!rst_n)
        (present && quiet_i) |=> tier_o == TIER_PLATMAX);

    a_r7_busy_active: assert property (@(posedge clk) disable iff (!rst_n)
        (present && !quiet_i && busy_i) |=> tier_o == TIER_ACTIVE);

    a_r5_act_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (tier_o == TIER_ACT_IDLE && $past(tier_o) != TIER_ACT_IDLE)
            |-> $past(tier_o) == TIER_ACTIVE);

    a_r6_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (tier_o == TIER_IDLE && $past(tier_o) != TIER_IDLE)
            |-> $past(tier_o) == TIER_ACT_IDLE);

endmodule

// File: rtl/lat_tol_select.sv
module lat_tol_select
    import lat_tol_pkg::*;
#(
    parameter lat_word_t W_ACT = 13'h083B,
    parameter lat_word_t W_AI  = 13'h0987
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tier_e     tier_i,
    input  lat_word_t plat_i,
    output lat_word_t sel_word_o,
    output logic      sel_noreq_o
);
    lat_word_t plat_clamped;

    // R10: platform maximum never below the active word
    assign plat_clamped = (dec_ns(plat_i) < dec_ns(W_ACT)) ? W_ACT : plat_i;

    always_comb begin
        sel_word_o  = '0;
        sel_noreq_o = 1'b0;
        unique case (tier_i)
            TIER_NOREQ:              sel_noreq_o = 1'b1;
            TIER_ACTIVE:             sel_word_o  = W_ACT;
            TIER_ACT_IDLE:           sel_word_o  = W_AI;
            TIER_IDLE, TIER_PLATMAX: sel_word_o  = plat_clamped;
            default:                 sel_noreq_o = 1'b1;
        endcase
    end

    a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_noreq_o |-> dec_ns(sel_word_o) >= 48'(FLOOR_NS));

endmodule

// File: rtl/lat_tol_send_q.sv
module lat_tol_send_q
    import lat_tol_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lat_word_t sel_word_i,
    input  logic      sel_noreq_i,
    input  logic      ready_i,
    output logic      valid_o,
    output lat_word_t word_o,
    output logic      noreq_o
);
    lat_word_t tgt_word_q;
    logic      tgt_noreq_q;
    logic      load;

    assign load = (sel_noreq_i != tgt_noreq_q) || (sel_word_i != tgt_word_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_word_q  <= '0;
            tgt_noreq_q <= 1'b1;
            valid_o     <= 1'b0;
            word_o      <= '0;
            noreq_o     <= 1'b1;
        end else if (load) begin
            tgt_word_q  <= sel_word_i;
            tgt_noreq_q <= sel_noreq_i;
            valid_o     <= 1'b1;
            word_o      <= sel_word_i;
            noreq_o     <= sel_noreq_i;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o);

    a_r8_change_raises_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({word_o, noreq_o}) |-> valid_o);

    a_r2_noreq_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        noreq_o |-> word_o == '0);

endmodule

// File: rtl/lat_tol_reporter.sv
module lat_tol_reporter
    import lat_tol_pkg::*;
#(
    parameter int     FILL_W      = 8,
    parameter int     CNT_W       = 16,
    parameter longint ACTIVE_NS   = 60000,
    parameter longint ACT_IDLE_NS = 400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up_i,
    input  logic              assoc_i,
    input  logic              quiet_i,
    input  logic              traffic_i,
    input  logic [FILL_W-1:0] fill_lvl_i,
    input  logic [FILL_W-1:0] fill_thr_i,
    input  logic [12:0]       plat_max_i,
    input  logic [CNT_W-1:0]  act_idle_cyc_i,
    input  logic [CNT_W-1:0]  idle_cyc_i,
    input  logic              rpt_ready_i,
    output logic              rpt_valid_o,
    output logic [12:0]       rpt_word_o,
    output logic              rpt_noreq_o
);
    localparam longint    ACT_NS_EFF = (ACTIVE_NS < FLOOR_NS) ? FLOOR_NS : ACTIVE_NS;
    localparam longint    AI_NS_EFF  = (ACT_IDLE_NS < ACT_IDLE_MIN_NS) ? ACT_IDLE_MIN_NS
                                                                       : ACT_IDLE_NS;
    localparam lat_word_t W_ACT      = enc_ns(ACT_NS_EFF);
    localparam lat_word_t W_AI       = enc_ns(AI_NS_EFF);

    tier_e     tier;
    lat_word_t sel_word, out_word;
    logic      sel_noreq, busy;

    assign busy = traffic_i || (fill_lvl_i >= fill_thr_i);  // R7

    lat_tol_tier_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up_i (link_up_i),
        .assoc_i   (assoc_i),
        .quiet_i   (quiet_i),
        .busy_i    (busy),
        .t1_i      (act_idle_cyc_i),
        .t2_i      (idle_cyc_i),
        .tier_o    (tier)
    );

    lat_tol_select #(.W_ACT(W_ACT), .W_AI(W_AI)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .tier_i      (tier),
        .plat_i      (lat_word_t'(plat_max_i)),
        .sel_word_o  (sel_word),
        .sel_noreq_o (sel_noreq)
    );

    lat_tol_send_q u_send (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_word_i  (sel_word),
        .sel_noreq_i (sel_noreq),
        .ready_i     (rpt_ready_i),
        .valid_o     (rpt_valid_o),
        .word_o      (out_word),
        .noreq_o     (rpt_noreq_o)
    );

    assign rpt_word_o = out_word;

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rpt_valid_o);

endmodule

// File: tb/lat_tol_reporter_tb_top.sv
module lat_tol_reporter_tb_top;
    localparam int FILL_W = 8;
    localparam int CNT_W  = 16;
    localparam logic [12:0] W_ACT = {3'd2, 10'd59};
    localparam logic [12:0] W_AI  = {3'd2, 10'd391};
    localparam logic [12:0] W_1MS = {3'd2, 10'd977};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              link_up = 1'b0, assoc = 1'b0, quiet = 1'b0, traffic = 1'b0;
    logic [FILL_W-1:0] fill = '0, thr = 8'd200;
    logic [12:0]       plat = W_1MS;
    logic [CNT_W-1:0]  t1 = 16'd4, t2 = 16'd6;
    logic              ready = 1'b0;
    logic              valid, noreq;
    logic [12:0]       word;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    lat_tol_reporter #(.FILL_W(FILL_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .assoc_i(assoc),
        .quiet_i(quiet), .traffic_i(traffic), .fill_lvl_i(fill), .fill_thr_i(thr),
        .plat_max_i(plat), .act_idle_cyc_i(t1), .idle_cyc_i(t2),
        .rpt_ready_i(ready), .rpt_valid_o(valid), .rpt_word_o(word), .rpt_noreq_o(noreq)
    );

    function automatic longint bdec(input logic [12:0] w);
        return longint'(w[9:0]) << (5 * int'(w[12:10]));
    endfunction

    function automatic logic [12:0] bplat(input logic [12:0] w);
        return (bdec(w) < bdec(W_ACT)) ? W_ACT : w;
    endfunction

    // Reference model: 0 noreq, 1 active, 2 act-idle, 3 idle, 4 platmax
    int          m_st = 0;
    longint      m_cnt = 0;
    logic        m_tn = 1'b1, m_pend = 1'b0, m_pn = 1'b1;
    logic [12:0] m_tw = '0, m_pw = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tn = 1'b1; m_tw = '0;
            m_pend = 1'b0; m_pn = 1'b1; m_pw = '0;
        end else begin
            logic        sn;
            logic [12:0] sw;
            bit          busy;
            longint      e1, e2;
            sn = (m_st == 0);
            sw = (m_st == 1) ? W_ACT : (m_st == 2) ? W_AI :
                 (m_st >= 3) ? bplat(plat) : 13'd0;
            if (sn != m_tn || sw != m_tw) begin
                m_tn = sn; m_tw = sw; m_pend = 1'b1; m_pn = sn; m_pw = sw;
            end else if (m_pend && ready) begin
                m_pend = 1'b0;
            end
            busy = traffic || (fill >= thr);
            e1 = (t1 == 0) ? 1 : longint'(t1);
            e2 = (t2 == 0) ? 1 : longint'(t2);
            if (!link_up || !assoc) begin m_st = 0; m_cnt = 0; end
            else if (quiet) begin m_st = 4; m_cnt = 0; end
            else if (busy) begin m_st = 1; m_cnt = 0; end
            else if (m_st == 0 || m_st == 4) begin m_st = 1; m_cnt = 0; end
            else if (m_st == 1) begin
                if (m_cnt + 1 >= e1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
            end else if (m_st == 2) begin
                if (m_cnt + 1 >= e2) begin m_st = 3; m_cnt = 0; end else m_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // R8 R9: cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk(valid == m_pend, "R9 model valid", longint'(valid), longint'(m_pend));
            chk(noreq == m_pn, "R2 model noreq", longint'(noreq), longint'(m_pn));
            chk(word == m_pw, "R8 model word", longint'(word), longint'(m_pw));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic accept();
        ready = 1'b1; wt(1); ready = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        wt(4);
        rst_n = 1'b1;
        wt(1);
        chk(valid == 1'b0, "R1 reset valid", longint'(valid), 0);
        chk(noreq == 1'b1, "R1 reset noreq", longint'(noreq), 1);
        chk(word == 13'd0, "R1 reset word", longint'(word), 0);
        model_on = 1'b1;

        link_up = 1; assoc = 1; traffic = 1;
        wt(3);
        chk(valid && !noreq && word == W_ACT, "R4 active word", longint'(word), longint'(W_ACT));
        accept();
        wt(5);
        chk(valid == 1'b0, "R8 no repeat", longint'(valid), 0);

        traffic = 0;
        wt(6);
        chk(valid && word == W_AI, "R5 act-idle word", longint'(word), longint'(W_AI));
        accept();
        wt(8);
        chk(valid && word == W_1MS, "R6 idle plat word", longint'(word), longint'(W_1MS));
        accept();

        fill = 8'd220;
        wt(3);
        chk(valid && word == W_ACT, "R7 fill forces active", longint'(word), longint'(W_ACT));
        accept();

        fill = 8'd0; t1 = 16'd0;
        wt(3);
        chk(valid && word == W_AI, "R11 zero timeout", longint'(word), longint'(W_AI));
        accept();
        t1 = 16'd4;

        quiet = 1; plat = {3'd1, 10'd10};
        wt(3);
        chk(valid && word == W_ACT, "R10 plat clamp", longint'(word), longint'(W_ACT));
        accept();
        plat = W_1MS;
        wt(3);
        chk(valid && word == W_1MS, "R3 quiet plat", longint'(word), longint'(W_1MS));
        accept();
        quiet = 0; traffic = 1;
        wt(3);
        chk(valid && word == W_ACT, "R9 pending active", longint'(word), longint'(W_ACT));
        link_up = 0;
        wt(3);
        chk(valid && noreq && word == 13'd0, "R9 replaced by noreq", longint'({noreq, word}), 64'h2000);
        accept();
        wt(2);
        chk(valid == 1'b0, "R9 cleared", longint'(valid), 0);
        link_up = 1; assoc = 0;
        wt(4);
        chk(!valid && noreq, "R2 unassociated", longint'({valid, noreq}), 1);

        for (int k = 0; k < 400; k++) begin
            link_up = ($urandom_range(0, 19) != 0);
            assoc   = ($urandom_range(0, 19) != 0);
            quiet   = ($urandom_range(0, 9) == 0);
            traffic = ($urandom_range(0, 2) == 0);
            fill    = 8'($urandom_range(0, 255));
            t1      = 16'($urandom_range(0, 6));
            t2      = 16'($urandom_range(0, 8));
            if ($urandom_range(0, 7) == 0) plat = 13'($urandom_range(0, 8191));
            for (int j = 0; j < int'($urandom_range(1, 20)); j++) begin
                ready = ($urandom_range(0, 1) == 1);
                wt(1);
            end
        end
        ready = 1'b0;
        wt(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule